// File: doc/BRIEF.md
# Register Access Channel State Machine

This block is the host-facing access channel of a serial register wrapper. Software loads a single 32-bit command word that carries a write/read flag, a halfword register address and 16 bits of write data. The channel hands the request to a serial back end, follows the transaction through a four-state machine, and for reads keeps the returned data on display until software acknowledges it.

A 32-bit status word shows the machine state, the held read data, the back end's sync-idle indication, a software-set initialisation-done bit, the channel enable bit and a sticky overrun flag. Software writes through a small select-addressed write port. The serial wire protocol is not part of this block. It is represented by a request/acknowledge port with a read-data bus.

Top module: `rac_chan`

## Requirements
- R1: A synchronous active-high reset puts the state at IDLE (code 0) and clears the held read data, enable, init-done, overrun and `be_req`.
- R2: Command word layout: bit 31 is the write flag (1 = write), bits 30:16 are the halfword address and bits 15:0 are the write data. An accepted command drives `be_req` high from the next cycle, with `be_write`, `be_addr` and `be_wdata` taken from those fields and held steady until `be_ack`.
- R3: A command write (select 0) is accepted only when the enable bit is 1 and the state is IDLE. When enable is 0 the write is ignored: the state stays IDLE and the overrun flag is not set.
- R4: A write stays in REQ (code 1) until `be_ack`, then returns to IDLE on the next cycle.
- R5: A read stays in REQ until `be_ack`, captures `be_rdata` on that cycle, spends exactly one cycle in WFDLE (code 2) and then enters WFVLDCLR (code 3).
- R6: In WFVLDCLR, the state and the read data in status bits 15:0 stay unchanged until software writes select 1 with bit 0 set. The next cycle the state is IDLE and the held data is 0. Writing that select with bit 0 clear, or writing it in any other state, has no effect.
- R7: A command write while enabled and not IDLE is dropped with no back-end request. It sets the overrun flag (status bit 22), and the flag stays set until reset.
- R8: Status layout: bits 15:0 held read data, 17:16 state code, 20 `be_sync_idle`, 21 init-done, 22 overrun, 23 enable. All other bits are 0.
- R9: Select 2 writes bit 0 into the enable bit. Select 3 writes bit 0 into the init-done bit. Both are reflected in the status word the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 2 | Target select: 0 command, 1 valid-clear, 2 enable, 3 init-done |
| sw_wdata | input | 32 | Software write data |
| status | output | 32 | Status word |
| be_sync_idle | input | 1 | Back-end sync-idle indication |
| be_req | output | 1 | Request to the back end |
| be_write | output | 1 | Request is a write |
| be_addr | output | 15 | Halfword address |
| be_wdata | output | 16 | Write data |
| be_ack | input | 1 | One-cycle completion from the back end |
| be_rdata | input | 16 | Read data, valid with `be_ack` |

## Verification
A corrupted state register shows up in status bits 17:16 on the very next cycle. A stuck or skipped state also shows up as a missing, extra or prolonged `be_req`, which the request monitor catches at the next transaction. A wrong capture or a failed clear of the held data is visible in status bits 15:0 one cycle after `be_ack` or after the valid-clear write. A lost overrun flag is visible as soon as a command is issued into a busy channel.

// File: rtl/rac_pkg.sv
package rac_pkg;

    localparam int ADDR_W  = 15;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = 32;
    localparam int SEL_W   = 2;

    localparam int ST_LSB   = DATA_W;
    localparam int SYNC_BIT = 20;
    localparam int INIT_BIT = 21;
    localparam int OVR_BIT  = 22;
    localparam int EN_BIT   = 23;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WFDLE = 2'd2,
        ST_WFVLD = 2'd3
    } rac_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD    = 2'd0,
        SEL_VLDCLR = 2'd1,
        SEL_EN     = 2'd2,
        SEL_INIT   = 2'd3
    } rac_sel_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rac_cmd_t;

    typedef struct packed {
        logic       en;
        logic       ovr;
        logic       init;
        logic       sync;
        rac_state_e st;
        logic [DATA_W-1:0] rd;
    } rac_stat_t;

    function automatic rac_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        rac_cmd_t c;
        c.wr   = w[WORD_W-1];
        c.addr = w[WORD_W-2 -: ADDR_W];
        c.data = w[DATA_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input rac_stat_t s);
        logic [WORD_W-1:0] w;
        w                   = '0;
        w[DATA_W-1:0]       = s.rd;
        w[ST_LSB +: 2]      = s.st;
        w[SYNC_BIT]         = s.sync;
        w[INIT_BIT]         = s.init;
        w[OVR_BIT]          = s.ovr;
        w[EN_BIT]           = s.en;
        return w;
    endfunction

endpackage

// File: rtl/rac_cmd.sv
module rac_cmd
    import rac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sw_wr,
    input  logic [SEL_W-1:0]     sw_sel,
    input  logic [WORD_W-1:0]    sw_wdata,
    input  rac_state_e           state,
    output rac_cmd_t             cmd,
    output logic                 launch,
    output logic                 vld_clr,
    output logic                 en,
    output logic                 init_done,
    output logic                 overrun
);

    logic cmd_wr;
    logic busy;

    assign cmd_wr  = sw_wr && (rac_sel_e'(sw_sel) == SEL_CMD);
    assign busy    = (state != ST_IDLE);
    assign launch  = cmd_wr && en && !busy;
    assign vld_clr = sw_wr && (rac_sel_e'(sw_sel) == SEL_VLDCLR) && sw_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            en        <= 1'b0;
            init_done <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (launch)
                cmd <= unpack_cmd(sw_wdata);
            if (cmd_wr && en && busy)
                overrun <= 1'b1;
            if (sw_wr && (rac_sel_e'(sw_sel) == SEL_EN))
                en <= sw_wdata[0];
            if (sw_wr && (rac_sel_e'(sw_sel) == SEL_INIT))
                init_done <= sw_wdata[0];
        end
    end

endmodule

// File: rtl/rac_fsm.sv
module rac_fsm
    import rac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic       is_write,
    input  logic       be_ack,
    input  logic       vld_clr,
    output rac_state_e state,
    output logic       capture
);

    rac_state_e nxt;

    assign capture = (state == ST_REQ) && be_ack && !is_write;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (launch) nxt = ST_REQ;
            ST_REQ:   if (be_ack) nxt = is_write ? ST_IDLE : ST_WFDLE;
            ST_WFDLE: nxt = ST_WFVLD;
            ST_WFVLD: if (vld_clr) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/rac_stat.sv
module rac_stat
    import rac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [DATA_W-1:0]  be_rdata,
    input  logic               vld_clr,
    input  rac_state_e         state,
    input  logic               sync_idle,
    input  logic               init_done,
    input  logic               overrun,
    input  logic               en,
    output logic [WORD_W-1:0]  status
);

    logic [DATA_W-1:0] hold;
    rac_stat_t         s;

    always_ff @(posedge clk) begin
        if (rst)
            hold <= '0;
        else if (capture)
            hold <= be_rdata;
        else if (vld_clr && state == ST_WFVLD)
            hold <= '0;
    end

    always_comb begin
        s.rd   = hold;
        s.st   = state;
        s.sync = sync_idle;
        s.init = init_done;
        s.ovr  = overrun;
        s.en   = en;
        status = pack_status(s);
    end

endmodule

// File: rtl/rac_chan.sv
module rac_chan
    import rac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_wr,
    input  logic [SEL_W-1:0]    sw_sel,
    input  logic [WORD_W-1:0]   sw_wdata,
    output logic [WORD_W-1:0]   status,
    input  logic                be_sync_idle,
    output logic                be_req,
    output logic                be_write,
    output logic [ADDR_W-1:0]   be_addr,
    output logic [DATA_W-1:0]   be_wdata,
    input  logic                be_ack,
    input  logic [DATA_W-1:0]   be_rdata
);

    rac_cmd_t   cmd;
    rac_state_e state;
    logic       launch, vld_clr, en, init_done, overrun, capture;

    rac_cmd u_cmd (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .state(state), .cmd(cmd), .launch(launch),
        .vld_clr(vld_clr), .en(en), .init_done(init_done), .overrun(overrun)
    );

    rac_fsm u_fsm (
        .clk(clk), .rst(rst), .launch(launch), .is_write(cmd.wr),
        .be_ack(be_ack), .vld_clr(vld_clr), .state(state), .capture(capture)
    );

    rac_stat u_stat (
        .clk(clk), .rst(rst), .capture(capture), .be_rdata(be_rdata),
        .vld_clr(vld_clr), .state(state), .sync_idle(be_sync_idle),
        .init_done(init_done), .overrun(overrun), .en(en), .status(status)
    );

    assign be_req   = (state == ST_REQ);
    assign be_write = cmd.wr;
    assign be_addr  = cmd.addr;
    assign be_wdata = cmd.data;

endmodule

// File: rtl/rac_chan_chk.sv
module rac_chan_chk
    import rac_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                sw_wr,
    input logic [SEL_W-1:0]    sw_sel,
    input logic [WORD_W-1:0]   sw_wdata,
    input logic [WORD_W-1:0]   status,
    input logic                be_sync_idle,
    input logic                be_req,
    input logic                be_write,
    input logic [ADDR_W-1:0]   be_addr,
    input logic [DATA_W-1:0]   be_wdata,
    input logic                be_ack,
    input logic [DATA_W-1:0]   be_rdata
);

    logic [1:0] st;
    logic       vclr;
    assign st   = status[ST_LSB +: 2];
    assign vclr = sw_wr && (sw_sel == 2'd1) && sw_wdata[0];

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (st == 2'd0 && status[DATA_W-1:0] == '0 && !be_req));

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (be_req && !be_ack) |=> (be_req && $stable(be_addr) && $stable(be_write) && $stable(be_wdata)));

    p_disabled_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && sw_sel == 2'd0 && !status[EN_BIT] && st == 2'd0) |=> (st == 2'd0));

    p_write_done_r4: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd1 && be_ack && be_write) |=> (st == 2'd0));

    p_wfdle_once_r5: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd2) |=> (st == 2'd3));

    p_hold_data_r6: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd3 && !vclr) |=> (st == 2'd3 && $stable(status[DATA_W-1:0])));

    p_clear_data_r6: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd3 && vclr) |=> (st == 2'd0 && status[DATA_W-1:0] == '0));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        status[OVR_BIT] |=> status[OVR_BIT]);

endmodule

bind rac_chan rac_chan_chk u_chk (.*);

// File: tb/rac_chan_tb.sv
module rac_chan_tb;
    import rac_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              sw_wr;
    logic [1:0]        sw_sel;
    logic [31:0]       sw_wdata;
    logic [31:0]       status;
    logic              be_sync_idle;
    logic              be_req, be_write;
    logic [14:0]       be_addr;
    logic [15:0]       be_wdata;
    logic              be_ack;
    logic [15:0]       be_rdata;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int lat_cnt = 0;
    int cycles = 0;
    logic prev_req = 1'b0;
    logic [31:0] exp_q[$];

    rac_chan u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_rd(input logic [14:0] a);
        return {a, 1'b0} ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // back-end model: one-cycle ack after lat extra cycles
    always @(negedge clk) begin
        if (be_ack) be_ack <= 1'b0;
        else if (be_req) begin
            if (lat_cnt >= lat) begin
                be_ack   <= 1'b1;
                be_rdata <= model_rd(be_addr);
                lat_cnt  <= 0;
            end else lat_cnt <= lat_cnt + 1;
        end
    end

    // monitor: compare each new back-end request with the scoreboard
    always @(negedge clk) begin
        if (!rst && be_req && !prev_req) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R7 unexpected request", {be_write, be_addr, be_wdata}, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk({be_write, be_addr, be_wdata} == e, "R2 request fields",
                    {be_write, be_addr, be_wdata}, e);
            end
        end
        prev_req <= be_req;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            chk(1'b0, "watchdog", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [31:0] d);
        step();
        sw_wr = 1'b1; sw_sel = sel; sw_wdata = d;
        step();
        sw_wr = 1'b0;
    endtask

    task automatic wait_ack();
        int n = 0;
        while (!be_ack && n < 50) begin
            chk(status[17:16] == 2'd1, "R4/R5 REQ held until ack", status[17:16], 2'd1);
            step(); n++;
        end
    endtask

    task automatic do_write(input logic [14:0] a, input logic [15:0] d, input int l);
        lat = l;
        exp_q.push_back({1'b1, a, d});
        sw_write(2'd0, {1'b1, a, d});
        chk(status[17:16] == 2'd1, "R2 state REQ after command", status[17:16], 2'd1);
        wait_ack();
        step();
        chk(status[17:16] == 2'd0, "R4 write back to IDLE", status[17:16], 2'd0);
    endtask

    task automatic do_read(input logic [14:0] a, input int l);
        lat = l;
        exp_q.push_back({1'b0, a, 16'h0});
        sw_write(2'd0, {1'b0, a, 16'h0});
        wait_ack();
        step();
        chk(status[17:16] == 2'd2, "R5 WFDLE after ack", status[17:16], 2'd2);
        step();
        chk(status[17:16] == 2'd3, "R5 WFVLDCLR next", status[17:16], 2'd3);
        chk(status[15:0] == model_rd(a), "R5 read data captured", status[15:0], model_rd(a));
    endtask

    task automatic finish_read(input logic [14:0] a);
        repeat (3) step();
        chk(status[17:16] == 2'd3 && status[15:0] == model_rd(a), "R6 data held",
            status[17:0], {2'd3, model_rd(a)});
        sw_write(2'd1, 32'h0);
        chk(status[17:16] == 2'd3, "R6 clear with bit0=0 ignored", status[17:16], 2'd3);
        sw_write(2'd1, 32'h1);
        chk(status[17:0] == 18'h0, "R6 clear returns IDLE, data 0", status[17:0], 18'h0);
    endtask

    initial begin
        rst = 1'b1; sw_wr = 1'b0; sw_sel = 2'd0; sw_wdata = '0;
        be_sync_idle = 1'b1; be_ack = 1'b0; be_rdata = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(status == 32'h0010_0000, "R1 reset status", status, 32'h0010_0000);
        chk(!be_req, "R1 no request after reset", be_req, 1'b0);

        sw_write(2'd0, {1'b0, 15'h0123, 16'h0});
        step();
        chk(status[17:16] == 2'd0 && !status[22], "R3 disabled command ignored",
            status[23:16], 8'h10);

        sw_write(2'd2, 32'h1);
        chk(status[23], "R9 enable bit set", status[23], 1'b1);
        sw_write(2'd3, 32'h1);
        chk(status[21], "R9 init-done set", status[21], 1'b1);
        be_sync_idle = 1'b0; step();
        chk(status == 32'h00A0_0000, "R8 status layout, sync low", status, 32'h00A0_0000);
        be_sync_idle = 1'b1; step();
        chk(status[20], "R8 sync-idle reflected", status[20], 1'b1);

        do_write(15'h0ABC, 16'hBEEF, 2);
        do_write(15'h7FFF, 16'hFFFF, 0);
        do_read(15'h0040, 0);
        finish_read(15'h0040);
        do_read(15'h1234, 4);
        finish_read(15'h1234);

        // overrun: command into a busy channel
        lat = 5;
        exp_q.push_back({1'b0, 15'h0222, 16'h0});
        sw_write(2'd0, {1'b0, 15'h0222, 16'h0});
        sw_write(2'd0, {1'b1, 15'h0333, 16'h1111});
        chk(status[22] && status[17:16] == 2'd1, "R7 overrun set, state REQ",
            {status[22], status[17:16]}, 3'b101);
        wait_ack();
        step(); step();
        chk(status[15:0] == model_rd(15'h0222), "R7 dropped command left read intact",
            status[15:0], model_rd(15'h0222));
        sw_write(2'd0, {1'b1, 15'h0444, 16'h2222});
        chk(status[17:16] == 2'd3, "R7 command in WFVLDCLR dropped", status[17:16], 2'd3);
        sw_write(2'd1, 32'h1);
        chk(status[22] && status[17:16] == 2'd0, "R7 overrun sticky", status[23:16], 8'hF0);

        sw_write(2'd1, 32'h1);
        step();
        chk(status[17:0] == 18'h0 && !be_req, "R6 clear in IDLE no effect", status[17:0], 18'h0);

        do_write(15'h0001, 16'h00A5, 1);
        repeat (4) step();
        chk(exp_q.size() == 0, "R2 all requests seen", exp_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule